// File: doc/BRIEF.md
# Hardware LRU Chunk List

This block keeps the allocated chunks of a cache in least-recently-used order. The order lives in a doubly linked list built from two on-chip pointer arrays indexed by chunk number: one holds each chunk's neighbour towards the most-recently-used end, and the other holds its neighbour towards the least-recently-used end. Head and tail registers mark the two ends, and a membership bit per chunk records which chunks are on the list. The host inserts a chunk when it allocates it, can remove a chunk explicitly, and on a cache miss issues a DEQUEUE that pops the least-recently-used chunk and returns its index.

Every data access reports the chunk it touched. These reports never stall the access path. A report goes into a small FIFO and is applied later, one per cycle, in a cycle that carries no host command. When the FIFO is full, the report is discarded and a saturating drop counter is incremented.

Top module: `lru_chunk_list`

## Requirements
- R1: An insert command (`cmd_op_i` = 2'b00) puts a chunk that is not on the list at the most-recently-used end. An insert of a chunk that is already listed leaves the order unchanged.
- R2: A touch of a listed chunk moves that chunk to the most-recently-used end. The relative order of the other chunks is kept.
- R3: A touch of the chunk already at the most-recently-used end, or of a chunk that is not listed, leaves the list unchanged.
- R4: A DEQUEUE command (`cmd_op_i` = 2'b10) on a non-empty list raises `rsp_valid_o` and `rsp_hit_o` in the following cycle, with `rsp_idx_o` set to the least-recently-used chunk. That chunk leaves the list.
- R5: A DEQUEUE on an empty list raises `rsp_valid_o` in the following cycle with `rsp_hit_o` low. `rsp_valid_o` is high only in the cycle after a DEQUEUE.
- R6: A remove command (`cmd_op_i` = 2'b01) takes a listed chunk off the list. A remove of an unlisted chunk has no effect. Code 2'b11 is a no-op command.
- R7: Touches are accepted in every cycle without a ready signal. While FIFO_DEPTH touches are pending, a further touch is discarded and `touch_drops_o` increments, saturating at its maximum value.
- R8: Any cycle with `cmd_valid_i` high executes the command, and no pending touch is applied in that cycle. Pending touches are applied in arrival order, one per cycle without a command.
- R9: After reset the list is empty, `touch_drops_o` is 0 and `rsp_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| touch_valid_i | input | 1 | An access touched a chunk |
| touch_idx_i | input | IW | Touched chunk index |
| cmd_valid_i | input | 1 | Host command present |
| cmd_op_i | input | 2 | 00 insert, 01 remove, 10 dequeue, 11 no-op |
| cmd_idx_i | input | IW | Chunk index for insert or remove |
| rsp_valid_o | output | 1 | DEQUEUE response strobe |
| rsp_hit_o | output | 1 | A chunk was popped |
| rsp_idx_o | output | IW | Popped chunk index |
| touch_drops_o | output | DROP_W | Saturating count of discarded touches |

## Verification
The assertions check invariants on every cycle: the member count matches the number of set membership bits, the head and tail are listed whenever the list is non-empty, a single-element list has head equal to tail, a DEQUEUE is answered in the next cycle and misses only on an empty list, a touch of the head leaves both ends unchanged, and a touch that arrives while the FIFO is full increments the drop counter. Only the bench scenarios can show the complete recency order after mixed inserts, touches and removes, and which touches were lost while commands held the list busy. The bench exposes both through the order of successive DEQUEUE results.

// File: rtl/lru_pkg.sv
package lru_pkg;
  typedef enum logic [1:0] {
    OP_INSERT  = 2'b00,
    OP_REMOVE  = 2'b01,
    OP_DEQUEUE = 2'b10,
    OP_NOP     = 2'b11
  } lru_op_e;
endpackage

// File: rtl/lru_touch_fifo.sv
module lru_touch_fifo #(
  parameter int DEPTH  = 4,
  parameter int IW     = 4,
  parameter int DROP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [IW-1:0]     push_idx_i,
  input  logic              pop_i,
  output logic              avail_o,
  output logic [IW-1:0]     head_idx_o,
  output logic [DROP_W-1:0] drops_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

  logic [IW-1:0]     mem_q [DEPTH];
  logic [PW-1:0]     wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [DROP_W-1:0] drops_q, drops_n;
  logic              full, do_push, do_pop, en;

  assign full       = (cnt_q == CW'(DEPTH));
  assign do_pop     = pop_i && (cnt_q != '0);
  assign do_push    = push_i && !full;
  assign avail_o    = (cnt_q != '0);
  assign head_idx_o = mem_q[rd_q];
  assign drops_o    = drops_q;
  assign en         = push_i || do_pop;

  always_comb begin
    wr_n    = wr_q;
    rd_n    = rd_q;
    cnt_n   = cnt_q;
    drops_n = drops_q;
    if (do_push) wr_n = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
    if (do_pop)  rd_n = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
    if (do_push && !do_pop) cnt_n = cnt_q + CW'(1);
    else if (!do_push && do_pop) cnt_n = cnt_q - CW'(1);
    if (push_i && full && drops_q != DROP_MAX) drops_n = drops_q + DROP_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
      drops_q <= '0;
    end else if (en) begin
      wr_q    <= wr_n;
      rd_q    <= rd_n;
      cnt_q   <= cnt_n;
      drops_q <= drops_n;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= push_idx_i;
  end

  AST_DROP_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && drops_q != DROP_MAX) |=> (drops_o == $past(drops_o) + DROP_W'(1))) else $error("drop"); // R7
  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)) else $error("bound"); // R7
endmodule

// File: rtl/lru_list_core.sv
module lru_list_core
  import lru_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  lru_op_e       cmd_op_i,
  input  logic [IW-1:0] cmd_idx_i,
  input  logic          touch_avail_i,
  input  logic [IW-1:0] touch_idx_i,
  output logic          touch_take_o,
  output logic          rsp_valid_o,
  output logic          rsp_hit_o,
  output logic [IW-1:0] rsp_idx_o
);
  localparam int CW = $clog2(N + 1);

  logic [IW-1:0] mru_q [N];
  logic [IW-1:0] lru_q [N];
  logic [IW-1:0] mru_n [N];
  logic [IW-1:0] lru_n [N];
  logic [N-1:0]  mem_q, mem_n;
  logic [IW-1:0] head_q, head_n, tail_q, tail_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          rv_q, rh_q, rh_n;
  logic [IW-1:0] ri_q;
  logic [IW-1:0] tgt, p_i, n_i;
  logic          do_unlink, do_link, is_deq, en;

  assign touch_take_o = touch_avail_i && !cmd_valid_i;
  assign is_deq       = cmd_valid_i && (cmd_op_i == OP_DEQUEUE);
  assign en           = cmd_valid_i || touch_take_o;
  assign tgt          = cmd_valid_i ? (is_deq ? tail_q : cmd_idx_i) : touch_idx_i;

  always_comb begin
    do_unlink = 1'b0;
    do_link   = 1'b0;
    if (cmd_valid_i) begin
      case (cmd_op_i)
        OP_INSERT:  do_link   = !mem_q[tgt];
        OP_REMOVE:  do_unlink = mem_q[tgt];
        OP_DEQUEUE: do_unlink = (cnt_q != '0);
        default:    ;
      endcase
    end else if (touch_take_o && mem_q[tgt] && head_q != tgt) begin
      do_unlink = 1'b1;
      do_link   = 1'b1;
    end
  end

  always_comb begin
    mru_n  = mru_q;
    lru_n  = lru_q;
    mem_n  = mem_q;
    head_n = head_q;
    tail_n = tail_q;
    cnt_n  = cnt_q;
    rh_n   = (cnt_q != '0);
    p_i    = mru_q[tgt];
    n_i    = lru_q[tgt];
    if (do_unlink) begin
      if (head_q == tgt) head_n = n_i; else lru_n[p_i] = n_i;
      if (tail_q == tgt) tail_n = p_i; else mru_n[n_i] = p_i;
      mem_n[tgt] = 1'b0;
      cnt_n      = cnt_q - CW'(1);
    end
    if (do_link) begin
      lru_n[tgt] = head_n;
      mru_n[tgt] = tgt;
      if (cnt_n == '0) tail_n = tgt; else mru_n[head_n] = tgt;
      head_n     = tgt;
      mem_n[tgt] = 1'b1;
      cnt_n      = cnt_n + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        mru_q[i] <= '0;
        lru_q[i] <= '0;
      end
      mem_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      mru_q  <= mru_n;
      lru_q  <= lru_n;
      mem_q  <= mem_n;
      head_q <= head_n;
      tail_q <= tail_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv_q <= 1'b0;
      rh_q <= 1'b0;
      ri_q <= '0;
    end else begin
      rv_q <= is_deq;
      if (is_deq) begin
        rh_q <= rh_n;
        ri_q <= tail_q;
      end
    end
  end

  assign rsp_valid_o = rv_q;
  assign rsp_hit_o   = rh_q;
  assign rsp_idx_o   = ri_q;

  AST_COUNT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mem_q) == int'(cnt_q)) else $error("count"); // R1
  AST_ENDS_LISTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (mem_q[head_q] && mem_q[tail_q])) else $error("ends"); // R4
  AST_SINGLE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(1)) |-> (head_q == tail_q)) else $error("single"); // R2
  AST_DEQ_ANSWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_deq |=> rsp_valid_o) else $error("answer"); // R4
  AST_DEQ_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_deq && cnt_q == '0) |=> !rsp_hit_o) else $error("empty"); // R5
  AST_HEAD_TOUCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (touch_take_o && cnt_q != '0 && head_q == touch_idx_i) |=> ($stable(head_q) && $stable(tail_q))) else $error("head"); // R3
  AST_CMD_BLOCKS_TOUCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> !touch_take_o) else $error("prio"); // R8
endmodule

// File: rtl/lru_chunk_list.sv
module lru_chunk_list
  import lru_pkg::*;
#(
  parameter int N_CHUNKS   = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int DROP_W     = 8,
  localparam int IW        = $clog2(N_CHUNKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              touch_valid_i,
  input  logic [IW-1:0]     touch_idx_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [IW-1:0]     cmd_idx_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [IW-1:0]     rsp_idx_o,
  output logic [DROP_W-1:0] touch_drops_o
);
  logic          q_avail, q_take;
  logic [IW-1:0] q_idx;

  lru_touch_fifo #(.DEPTH(FIFO_DEPTH), .IW(IW), .DROP_W(DROP_W)) fifo_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (touch_valid_i),
    .push_idx_i (touch_idx_i),
    .pop_i      (q_take),
    .avail_o    (q_avail),
    .head_idx_o (q_idx),
    .drops_o    (touch_drops_o)
  );

  lru_list_core #(.N(N_CHUNKS), .IW(IW)) core_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_valid_i   (cmd_valid_i),
    .cmd_op_i      (lru_op_e'(cmd_op_i)),
    .cmd_idx_i     (cmd_idx_i),
    .touch_avail_i (q_avail),
    .touch_idx_i   (q_idx),
    .touch_take_o  (q_take),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_hit_o     (rsp_hit_o),
    .rsp_idx_o     (rsp_idx_o)
  );
endmodule

// File: tb/lru_chunk_list_tb_top.sv
module lru_chunk_list_tb_top;
  localparam int N = 16;
  localparam int D = 4;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic touch_valid = 1'b0;
  logic [IW-1:0] touch_idx = '0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b11;
  logic [IW-1:0] cmd_idx = '0;
  logic rsp_valid, rsp_hit;
  logic [IW-1:0] rsp_idx;
  logic [7:0] drops;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int model[$];
  bit exp_hit[$];
  int exp_idx[$];
  string exp_req[$];

  always #2 clk = ~clk;

  lru_chunk_list #(.N_CHUNKS(N), .FIFO_DEPTH(D), .DROP_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .touch_valid_i(touch_valid), .touch_idx_i(touch_idx),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_idx_i(cmd_idx),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_idx_o(rsp_idx),
    .touch_drops_o(drops)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int find(input int x);
    foreach (model[i]) if (model[i] == x) return i;
    return -1;
  endfunction

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_hit.size() == 0) begin
        check(0, "R5 unexpected response", 1, 0);
      end else begin
        automatic bit eh = exp_hit.pop_front();
        automatic int ei = exp_idx.pop_front();
        automatic string er = exp_req.pop_front();
        check(rsp_hit == eh, {er, " hit"}, rsp_hit, eh);
        if (eh) check(int'(rsp_idx) == ei, {er, " idx"}, rsp_idx, ei);
      end
    end
  end

  task automatic cmd(input logic [1:0] op, input int x);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = IW'(x);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b11;
  endtask

  task automatic ins(input int x);
    if (find(x) < 0) model.push_back(x);
    cmd(2'b00, x);
  endtask

  task automatic rem(input int x);
    automatic int k = find(x);
    if (k >= 0) model.delete(k);
    cmd(2'b01, x);
  endtask

  task automatic deq(input string req);
    if (model.size() == 0) begin
      exp_hit.push_back(1'b0); exp_idx.push_back(0);
    end else begin
      exp_hit.push_back(1'b1); exp_idx.push_back(model.pop_front());
    end
    exp_req.push_back(req);
    cmd(2'b10, 0);
  endtask

  function automatic void touch_model(input int x);
    automatic int k = find(x);
    if (k >= 0 && k != model.size() - 1) begin
      model.delete(k);
      model.push_back(x);
    end
  endfunction

  task automatic touch(input int x);
    touch_model(x);
    touch_valid = 1'b1; touch_idx = IW'(x);
    @(negedge clk);
    touch_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R9 rsp_valid after reset", rsp_valid, 0);
    check(drops == 8'd0, "R9 drops after reset", drops, 0);
    rst_n = 1'b1;
    @(negedge clk);
    deq("R5 empty after reset");
    settle();
    check(rsp_valid == 1'b0, "R5 strobe only once", rsp_valid, 0);

    ins(3); ins(7); ins(1); ins(9);
    ins(7);                       // R1 duplicate insert ignored
    touch(3);                     // R2 moves 3 to MRU
    touch(3);                     // R3 head touch
    touch(12);                    // R3 unlisted touch
    rem(1);                       // R6 remove listed
    rem(5);                       // R6 remove unlisted
    cmd(2'b11, 9);                // R6 no-op command
    deq("R4 pop 7");
    deq("R4 pop 9");
    ins(4);
    deq("R2 pop 3");
    deq("R1 pop 4");
    deq("R5 empty after drain");
    settle();

    for (int i = 0; i < 6; i++) ins(i);
    // R8: commands hold the list busy while touches queue; R7 drops the overflow
    cmd_valid = 1'b1; cmd_op = 2'b11;
    for (int i = 0; i < 6; i++) begin
      touch_valid = 1'b1; touch_idx = IW'(i);
      if (i < D) touch_model(i);
      @(negedge clk);
    end
    touch_valid = 1'b0;
    @(negedge clk);
    check(drops == 8'd2, "R7 drop count", drops, 2);
    cmd_valid = 1'b0;
    repeat (D + 2) @(negedge clk);
    for (int i = 0; i < 6; i++) deq("R8 order after queued touches");
    deq("R5 empty at end");
    settle();
    check(exp_hit.size() == 0, "R4 all responses seen", exp_hit.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule